// File: doc/BRIEF.md
# Single-Precision Operand Classifier with NaN Quieting

This block looks at one packed single-precision operand and reports which of six classes it belongs to, together with a flag that is high for any not-a-number encoding. It also produces the value that a NaN operand would become when it is propagated as a result, and raises an invalid-operation flag when that operand is signalling.

The block uses the older signalling convention. When the most significant fraction bit is set, the NaN is signalling. When that bit is clear, the NaN is quiet. An input chooses between two ways of handling a signalling NaN. With the invalid trap enabled, the operand is passed back untouched so that a trap handler can see it. With the trap disabled, the signalling bit is cleared. If clearing that bit would leave a zero fraction, which would read as infinity, a fixed default NaN is returned instead.

The block is purely combinational. Choosing between two NaN operands, arithmetic and trap delivery belong to the surrounding datapath.

Top module: `fp32_class_nan`

## Requirements
- R1: An operand with exponent field 0 and fraction 0 has class code 0 (zero). This holds for either sign.
- R2: An operand with exponent field 0 and a non-zero fraction has class code 2 (denormal).
- R3: An operand whose exponent field is neither 0 nor all ones has class code 1 (normal).
- R4: An operand with an all-ones exponent field and fraction 0 has class code 3 (infinity).
- R5: An operand with an all-ones exponent field and a non-zero fraction is a NaN. Its class code is 4 (signalling) when fraction bit 22 (operand bit 22) is set, and 5 (quiet) otherwise.
- R6: The NaN flag is high exactly when the class code is 4 or higher.
- R7: For a quiet NaN, the result equals the operand and the invalid flag is low.
- R8: For a signalling NaN, the invalid flag is high whatever the trap-enable input is.
- R9: For a signalling NaN with the trap enabled, the result equals the operand bit for bit.
- R10: For a signalling NaN with the trap disabled and at least one fraction bit below bit 22 set, the result is the operand with bit 22 cleared. Sign, exponent and the lower fraction bits are unchanged.
- R11: For a signalling NaN with the trap disabled whose only set fraction bit is bit 22, the result is 0x7FBFFFFF.
- R12: For any operand that is not a NaN, the result equals the operand and the invalid flag is low, whatever the trap-enable input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Packed operand: sign bit 31, exponent bits 30:23, fraction bits 22:0 |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| class_o | output | 3 | Class code (0 zero, 1 normal, 2 denormal, 3 infinity, 4 signalling NaN, 5 quiet NaN) |
| is_nan_o | output | 1 | High for either NaN class |
| result_o | output | 32 | Propagated value |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The assertions run on every evaluation of the outputs. They check that the NaN flag agrees with the class code, that quiet NaNs and non-NaNs pass through without the invalid flag, that every signalling NaN raises the invalid flag, and that a quieted result is a NaN with bit 22 clear. Only the bench's scenarios show the exact class boundaries. These include the smallest and largest denormal, the smallest normal and the largest finite value. The bench scenarios are also the only check of the exact default pattern returned for a signalling NaN whose sole fraction bit is bit 22, and of sign preservation when quieting.

// File: rtl/fp_class_pkg.sv
package fp_class_pkg;

   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_ZERO   = 3'd0,
      CLS_NORMAL = 3'd1,
      CLS_DENORM = 3'd2,
      CLS_INF    = 3'd3,
      CLS_SNAN   = 3'd4,
      CLS_QNAN   = 3'd5
   } fp_cls_e;

   // every NaN code sits at or above this value
   localparam logic [CLS_W-1:0] CLS_NAN_FLOOR = CLS_SNAN;

endpackage

// File: rtl/fp_field_split.sv
module fp_field_split #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] word_i,
   output logic         sign_o,
   output logic         exp_ones_o,
   output logic         exp_zero_o,
   output logic         frac_msb_o,
   output logic         frac_low_zero_o,
   output logic         frac_zero_o
);

   generate
      if (EXP_W < 2)  begin : g_bad_exp  $error("EXP_W must be at least 2");  end
      if (FRAC_W < 2) begin : g_bad_frac $error("FRAC_W must be at least 2"); end
   endgenerate

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   always_comb begin
      sign_o          = word_i[W-1];
      exp_f           = word_i[W-2 -: EXP_W];
      frac_f          = word_i[FRAC_W-1:0];
      exp_ones_o      = &exp_f;
      exp_zero_o      = ~|exp_f;
      frac_msb_o      = frac_f[FRAC_W-1];
      frac_low_zero_o = ~|frac_f[FRAC_W-2:0];
      frac_zero_o     = ~frac_msb_o & frac_low_zero_o;
   end

endmodule

// File: rtl/fp_class_decode.sv
module fp_class_decode
   import fp_class_pkg::*;
(
   input  logic    exp_ones_i,
   input  logic    exp_zero_i,
   input  logic    frac_msb_i,
   input  logic    frac_zero_i,
   output fp_cls_e cls_o
);

   always_comb begin
      if (exp_zero_i)
         cls_o = frac_zero_i ? CLS_ZERO : CLS_DENORM;
      else if (!exp_ones_i)
         cls_o = CLS_NORMAL;
      else if (frac_zero_i)
         cls_o = CLS_INF;
      else
         // legacy convention: top fraction bit set marks signalling
         cls_o = frac_msb_i ? CLS_SNAN : CLS_QNAN;
   end

endmodule

// File: rtl/fp_nan_resolve.sv
module fp_nan_resolve
   import fp_class_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] word_i,
   input  fp_cls_e      cls_i,
   input  logic         frac_low_zero_i,
   input  logic         trap_en_i,
   output logic [W-1:0] result_o,
   output logic         invalid_o
);

   // default NaN: positive, exponent all ones, top fraction bit clear, rest set
   localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
   localparam logic [W-1:0] QUIET_MASK  = ~(W'(1) << (FRAC_W-1));

   logic is_snan;

   always_comb begin
      is_snan   = (cls_i == CLS_SNAN);
      invalid_o = is_snan;
      result_o  = word_i;
      if (is_snan && !trap_en_i)
         result_o = frac_low_zero_i ? DEFAULT_NAN : (word_i & QUIET_MASK);
   end

endmodule

// File: rtl/fp32_class_nan.sv
module fp32_class_nan
   import fp_class_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]     operand_i,
   input  logic             trap_en_i,
   output logic [CLS_W-1:0] class_o,
   output logic             is_nan_o,
   output logic [W-1:0]     result_o,
   output logic             invalid_o
);

   logic    sign_w, exp_ones_w, exp_zero_w, frac_msb_w, frac_low_zero_w, frac_zero_w;
   fp_cls_e cls_w;

   fp_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
      .word_i          (operand_i),
      .sign_o          (sign_w),
      .exp_ones_o      (exp_ones_w),
      .exp_zero_o      (exp_zero_w),
      .frac_msb_o      (frac_msb_w),
      .frac_low_zero_o (frac_low_zero_w),
      .frac_zero_o     (frac_zero_w)
   );

   fp_class_decode u_decode (
      .exp_ones_i  (exp_ones_w),
      .exp_zero_i  (exp_zero_w),
      .frac_msb_i  (frac_msb_w),
      .frac_zero_i (frac_zero_w),
      .cls_o       (cls_w)
   );

   fp_nan_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_resolve (
      .word_i          (operand_i),
      .cls_i           (cls_w),
      .frac_low_zero_i (frac_low_zero_w),
      .trap_en_i       (trap_en_i),
      .result_o        (result_o),
      .invalid_o       (invalid_o)
   );

   always_comb begin
      class_o  = cls_w;
      is_nan_o = exp_ones_w & ~frac_zero_w;
   end

   logic unused_sign;
   assign unused_sign = sign_w;

   always_comb begin
      if (!$isunknown({operand_i, trap_en_i})) begin
         AST_NAN_FLAG_MATCH: assert (is_nan_o == (class_o >= CLS_NAN_FLOOR)); // R6
         AST_QNAN_PASS: assert (class_o != CLS_QNAN || (result_o == operand_i && !invalid_o)); // R7
         AST_SNAN_INVALID: assert (class_o != CLS_SNAN || invalid_o); // R8
         AST_TRAP_KEEP: assert (!(class_o == CLS_SNAN && trap_en_i) || result_o == operand_i); // R9
         AST_QUIETED_IS_NAN: assert (!(class_o == CLS_SNAN && !trap_en_i) ||
            (&result_o[W-2 -: EXP_W] && !result_o[FRAC_W-1] && |result_o[FRAC_W-2:0])); // R10
         AST_NONNAN_PASS: assert (is_nan_o || (result_o == operand_i && !invalid_o)); // R12
      end
   end

endmodule

// File: tb/sim_fp32_class_nan.sv
module sim_fp32_class_nan;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opnd;
   logic        trap;
   logic [2:0]  cls;
   logic        isnan;
   logic [31:0] res;
   logic        inv;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fp32_class_nan u0 (
      .operand_i (opnd),
      .trap_en_i (trap),
      .class_o   (cls),
      .is_nan_o  (isnan),
      .result_o  (res),
      .invalid_o (inv)
   );

   function automatic int ref_class(input logic [31:0] v);
      int e = int'(v[30:23]);
      int f = int'(v[22:0]);
      if (e == 0)   return (f == 0) ? 0 : 2;
      if (e == 255) return (f == 0) ? 3 : ((f >= 4194304) ? 4 : 5);
      return 1;
   endfunction

   function automatic string class_tag(input int c);
      case (c)
         0: return "R1";
         1: return "R3";
         2: return "R2";
         3: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s operand=%08h trap=%0b actual=%08h expected=%08h", tag, opnd, trap, act, exp_v);
      end
   endtask

   task automatic apply(input logic [31:0] v, input logic t);
      int c;
      logic [31:0] er;
      logic ei;
      @(posedge clk);
      #1;
      opnd = v;
      trap = t;
      @(negedge clk);
      c  = ref_class(v);
      er = v;
      ei = (c == 4);
      if (c == 4 && !t) begin
         er = v & ~32'h0040_0000;
         if (er[22:0] == 0) er = 32'h7FBF_FFFF;
      end
      chk(class_tag(c), {29'd0, cls}, c);
      chk("R6", {31'd0, isnan}, {31'd0, (c >= 4)});
      if (c == 5) begin
         chk("R7", res, er); chk("R7", {31'd0, inv}, 0);
      end else if (c == 4) begin
         chk("R8", {31'd0, inv}, 1);
         if (t) chk("R9", res, er);
         else if (v[21:0] == 0) chk("R11", res, er);
         else chk("R10", res, er);
      end else begin
         chk("R12", res, er); chk("R12", {31'd0, inv}, {31'd0, ei});
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] vecs [16];
      int unsigned s;
      opnd = 32'h0;
      trap = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: zero operand gives class zero, no flags
      chk("R1", {29'd0, cls}, 0);
      chk("R12", {31'd0, inv}, 0);
      vecs = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
               32'h0080_0000, 32'h3F80_0000, 32'h7F7F_FFFF, 32'h7F80_0000,
               32'hFF80_0000, 32'h7F80_0001, 32'h7FBF_FFFF, 32'hFFC0_0000,
               32'h7FC0_0000, 32'h7FFF_FFFF, 32'hFFC0_0001, 32'h7FE0_0000};
      foreach (vecs[i]) begin
         apply(vecs[i], 1'b0);
         apply(vecs[i], 1'b1);
      end
      s = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         // bias half the stimulus toward NaN encodings
         if (k % 2 == 0) apply(s | 32'h7F80_0000, s[3]);
         else apply(s, s[7]);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule